// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory command into the stream of per-element byte addresses that a memory unit sends to a set of DRAM macros. A command supplies a start address, a signed element stride, an element width code, an element count and a mode. The block then issues one address per cycle over a valid/ready handshake until the requested number of elements has gone out. It then pulses a completion strobe.

Three ways of walking memory are offered. Unit stride visits consecutive elements. Constant stride skips a fixed signed number of elements between accesses. Indexed mode takes a signed element offset from a separate index stream for each access, which serves both gathers and scatters. Every address carries the number of the DRAM macro that holds it. Every address also carries a flag that marks an element not aligned to its own size. The vector as a whole has no alignment rule.

Top module: `vec_agen`

## Requirements
- R1: A command is taken on a cycle with `cmdValid` and `cmdReady` both high. `cmdReady` is high only when no command is in progress and `done` is low. After reset `addrValid` and `done` are low and `cmdReady` is high.
- R2: The element size in bytes is 1, 2, 4 or 8 for `cmdWidth` codes 0, 1, 2 and 3. In unit mode (`cmdMode` 0), issued address k is `cmdBase + k*size`, modulo 2^32.
- R3: In stride mode (`cmdMode` 1), issued address k is `cmdBase + k*cmdStride*size`. `cmdStride` is a signed two's-complement element count.
- R4: In indexed mode (`cmdMode` 2), each issued address is `cmdBase + idx*size`, where idx is the signed value on `idxData`. `addrValid` follows `idxValid`. One index is consumed, with `idxReady` high, exactly on each address handshake.
- R5: `addrMisal` is high exactly when the low log2(size) bits of `addrOut` are not all zero. Byte elements are never flagged.
- R6: `addrBank` equals `addrOut` bits [10:8]. Each macro page holds 256 bytes and there are 8 macros.
- R7: Exactly `cmdLen` addresses are issued per command. A length of zero issues none and raises `done` in the cycle after acceptance.
- R8: In unit and stride modes, while `addrValid` is high and `addrReady` is low, `addrOut` holds its value until the handshake.
- R9: `done` is high for exactly one cycle, in the cycle after the last address handshake.
- R10: Mode code 3 walks memory exactly as unit mode does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be taken |
| cmdMode | input | 2 | 0 unit, 1 stride, 2 indexed, 3 as unit |
| cmdBase | input | ADDR_W | Start byte address |
| cmdStride | input | STRIDE_W | Signed stride in elements |
| cmdWidth | input | 2 | Element size code |
| cmdLen | input | VL_W | Number of elements |
| idxValid | input | 1 | Index value offered |
| idxReady | output | 1 | Index value consumed |
| idxData | input | IDX_W | Signed element index |
| addrValid | output | 1 | Element address offered |
| addrReady | input | 1 | Downstream takes the address |
| addrOut | output | ADDR_W | Element byte address |
| addrBank | output | BANK_W | Target DRAM macro |
| addrMisal | output | 1 | Element not aligned to its size |
| done | output | 1 | One-cycle completion strobe |

## Verification
Several properties are checked on every cycle. The completion strobe never lasts two cycles. An index is consumed only together with an address handshake. Byte elements are never flagged as misaligned. A stalled unit or stride address stays stable. An active command always has a nonzero remaining count. The bench scenarios cover what needs a reference sequence. These are the exact address series for each mode and width, including negative strides and indices. They also cover bank changes across page boundaries, wrap across the top bank, exact element counts, the zero-length case and the timing of the completion strobe.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } agenMode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agenState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // command accepted: capture base, step, width
    logic advance;  // one element address handed over
  } agenStrobe_t;

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdMode,
  input  logic [VL_W-1:0] cmdLen,
  input  logic            addrReady,
  input  logic            idxValid,
  output logic            cmdReady,
  output logic            addrValid,
  output logic            idxReady,
  output logic            done,
  output agenMode_e       curMode,
  output agenStrobe_t     strobe
);

  agenState_e      stateQ;
  logic [VL_W-1:0] remQ;
  logic            doneQ;
  logic            accept;
  logic            isIdx;
  logic            running;
  logic            handshake;
  logic            lastElem;

  assign running   = (stateQ == ST_RUN);
  assign isIdx     = (curMode == MODE_INDEX);
  assign cmdReady  = !running && !doneQ;
  assign accept    = cmdValid && cmdReady;
  assign addrValid = running && (!isIdx || idxValid);
  assign idxReady  = running && isIdx && addrReady;
  assign handshake = addrValid && addrReady;
  assign lastElem  = handshake && (remQ == VL_W'(1));
  assign done      = doneQ;

  always_comb begin
    strobe.load    = accept;
    strobe.advance = handshake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remQ    <= '0;
      curMode <= MODE_UNIT;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (accept && (cmdLen == '0)) || lastElem;
      if (accept) begin
        curMode <= agenMode_e'(cmdMode);
        remQ    <= cmdLen;
        stateQ  <= (cmdLen == '0) ? ST_IDLE : ST_RUN;
      end else if (handshake) begin
        remQ <= remQ - VL_W'(1);
        if (lastElem) stateQ <= ST_IDLE;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_IDX_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && idxReady) |-> (addrValid && addrReady)); // R4

  AST_ACTIVE_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (remQ != '0)); // R7

  AST_READY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !addrValid); // R1

endmodule

// File: rtl/agen_dp.sv
module agen_dp
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int IDX_W      = 16,
  parameter int BANK_CNT   = 8,
  parameter int PAGE_BYTES = 256,
  localparam int BANK_W    = $clog2(BANK_CNT),
  localparam int PAGE_LSB  = $clog2(PAGE_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  agenStrobe_t         strobe,
  input  logic [1:0]          cmdMode,
  input  logic [ADDR_W-1:0]   cmdBase,
  input  logic [STRIDE_W-1:0] cmdStride,
  input  logic [1:0]          cmdWidth,
  input  agenMode_e           curMode,
  input  logic [IDX_W-1:0]    idxData,
  output logic [ADDR_W-1:0]   addrOut,
  output logic [BANK_W-1:0]   addrBank,
  output logic                addrMisal
);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] curQ;
  logic [ADDR_W-1:0] stepQ;
  logic [1:0]        widthQ;
  logic [ADDR_W-1:0] strideExt;
  logic [ADDR_W-1:0] idxExt;
  logic [ADDR_W-1:0] stepNext;
  logic [ADDR_W-1:0] idxOffset;
  logic [ADDR_W-1:0] alignMask;
  logic              isIdx;

  assign isIdx     = (curMode == MODE_INDEX);
  assign strideExt = {{(ADDR_W-STRIDE_W){cmdStride[STRIDE_W-1]}}, cmdStride};
  assign idxExt    = {{(ADDR_W-IDX_W){idxData[IDX_W-1]}}, idxData};

  // a left shift scales a two's-complement count by the element size
  always_comb begin
    if (agenMode_e'(cmdMode) == MODE_STRIDE) stepNext = strideExt << cmdWidth;
    else                                     stepNext = ADDR_W'(1) << cmdWidth;
  end

  assign idxOffset = idxExt << widthQ;
  assign addrOut   = isIdx ? (baseQ + idxOffset) : curQ;
  assign alignMask = (ADDR_W'(1) << widthQ) - ADDR_W'(1);
  assign addrMisal = |(addrOut & alignMask);
  assign addrBank  = addrOut[PAGE_LSB +: BANK_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      curQ   <= '0;
      stepQ  <= '0;
      widthQ <= '0;
    end else if (strobe.load) begin
      baseQ  <= cmdBase;
      curQ   <= cmdBase;
      stepQ  <= stepNext;
      widthQ <= cmdWidth;
    end else if (strobe.advance && !isIdx) begin
      curQ <= curQ + stepQ;
    end
  end

  AST_BYTE_NEVER_MISAL: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ == 2'd0) |-> !addrMisal); // R5

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance && !isIdx) |=> $stable(addrOut)); // R8

endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int IDX_W      = 16,
  parameter int VL_W       = 7,
  parameter int BANK_CNT   = 8,
  parameter int PAGE_BYTES = 256,
  localparam int BANK_W    = $clog2(BANK_CNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [1:0]          cmdMode,
  input  logic [ADDR_W-1:0]   cmdBase,
  input  logic [STRIDE_W-1:0] cmdStride,
  input  logic [1:0]          cmdWidth,
  input  logic [VL_W-1:0]     cmdLen,
  input  logic                idxValid,
  output logic                idxReady,
  input  logic [IDX_W-1:0]    idxData,
  output logic                addrValid,
  input  logic                addrReady,
  output logic [ADDR_W-1:0]   addrOut,
  output logic [BANK_W-1:0]   addrBank,
  output logic                addrMisal,
  output logic                done
);

  agenStrobe_t strobe;
  agenMode_e   curMode;

  agen_ctrl #(.VL_W(VL_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdMode   (cmdMode),
    .cmdLen    (cmdLen),
    .addrReady (addrReady),
    .idxValid  (idxValid),
    .cmdReady  (cmdReady),
    .addrValid (addrValid),
    .idxReady  (idxReady),
    .done      (done),
    .curMode   (curMode),
    .strobe    (strobe)
  );

  agen_dp #(
    .ADDR_W     (ADDR_W),
    .STRIDE_W   (STRIDE_W),
    .IDX_W      (IDX_W),
    .BANK_CNT   (BANK_CNT),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdMode   (cmdMode),
    .cmdBase   (cmdBase),
    .cmdStride (cmdStride),
    .cmdWidth  (cmdWidth),
    .curMode   (curMode),
    .idxData   (idxData),
    .addrOut   (addrOut),
    .addrBank  (addrBank),
    .addrMisal (addrMisal)
  );

endmodule

// File: tb/sim_vec_agen.sv
module sim_vec_agen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdMode = 2'd0;
  logic [31:0] cmdBase = '0;
  logic [15:0] cmdStride = '0;
  logic [1:0]  cmdWidth = 2'd0;
  logic [6:0]  cmdLen = '0;
  logic        idxValid = 1'b0;
  logic        idxReady;
  logic [15:0] idxData = '0;
  logic        addrValid;
  logic        addrReady = 1'b0;
  logic [31:0] addrOut;
  logic [2:0]  addrBank;
  logic        addrMisal;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int idxMem [0:15];

  always #4 clk = ~clk; // 125 MHz

  vec_agen u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdMode(cmdMode), .cmdBase(cmdBase), .cmdStride(cmdStride),
    .cmdWidth(cmdWidth), .cmdLen(cmdLen), .idxValid(idxValid),
    .idxReady(idxReady), .idxData(idxData), .addrValid(addrValid),
    .addrReady(addrReady), .addrOut(addrOut), .addrBank(addrBank),
    .addrMisal(addrMisal), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // issues one command and checks every address, the count and the done timing
  task automatic runVec(input logic [1:0] mode, input logic [31:0] base,
                        input int stride, input int w, input int len,
                        input logic [7:0] rdyMask, input logic [7:0] ivMask,
                        input string name);
    int k = 0;
    int size = 1 << w;
    int lastHs = -1;
    int doneCyc = -1;
    bit prevValid = 0;
    bit prevReady = 0;
    logic [31:0] prevAddr = '0;
    logic [31:0] expAddr;
    $display("scenario %s", name);
    @(negedge clk);
    cmdMode = mode; cmdBase = base; cmdStride = 16'(stride);
    cmdWidth = 2'(w); cmdLen = 7'(len); cmdValid = 1'b1;
    #1;
    chk(cmdReady == 1'b1, "R1", "cmdReady when idle", longint'(cmdReady), 1);
    for (int cyc = 0; cyc < 120; cyc++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      addrReady = rdyMask[cyc % 8];
      idxValid = (mode == 2'd2) && (k < len) && ivMask[cyc % 8];
      idxData = 16'(idxMem[k % 16]);
      #1;
      if (cyc == 0 && len > 0)
        chk(cmdReady == 1'b0, "R1", "cmdReady busy", longint'(cmdReady), 0);
      if (mode == 2'd2 && !idxValid)
        chk(addrValid == 1'b0, "R4", "valid without index", longint'(addrValid), 0);
      if (prevValid && !prevReady && mode != 2'd2) begin
        chk(addrValid == 1'b1, "R8", "valid held in stall", longint'(addrValid), 1);
        chk(addrOut == prevAddr, "R8", "addr held in stall", longint'(addrOut), longint'(prevAddr));
      end
      if (done) begin
        doneCyc = cyc;
        break;
      end
      if (addrValid && addrReady) begin
        if (mode == 2'd2) expAddr = base + 32'(idxMem[k] * size);
        else if (mode == 2'd1) expAddr = base + 32'(k * stride * size);
        else expAddr = base + 32'(k * size);
        chk(addrOut == expAddr, (mode == 2'd2) ? "R4" : (mode == 2'd1) ? "R3" :
            (mode == 2'd3) ? "R10" : "R2", "address", longint'(addrOut), longint'(expAddr));
        chk(addrBank == expAddr[10:8], "R6", "bank", longint'(addrBank), longint'(expAddr[10:8]));
        chk(addrMisal == ((expAddr & 32'(size - 1)) != 0), "R5", "misalign flag",
            longint'(addrMisal), longint'((expAddr & 32'(size - 1)) != 0));
        if (mode == 2'd2)
          chk(idxReady == 1'b1, "R4", "index consumed", longint'(idxReady), 1);
        lastHs = cyc;
        k++;
      end
      prevValid = addrValid; prevReady = addrReady; prevAddr = addrOut;
    end
    chk(k == len, "R7", "element count", longint'(k), longint'(len));
    chk(doneCyc == ((len == 0) ? 0 : lastHs + 1), "R9", "done cycle",
        longint'(doneCyc), longint'((len == 0) ? 0 : lastHs + 1));
    @(negedge clk);
    addrReady = 1'b0; idxValid = 1'b0;
    #1;
    chk(done == 1'b0, "R9", "done one cycle", longint'(done), 0);
    chk(addrValid == 1'b0, "R7", "no extra address", longint'(addrValid), 0);
  endtask

  task automatic testReset();
    #1;
    chk(addrValid == 1'b0, "R1", "reset addrValid", longint'(addrValid), 0);
    chk(done == 1'b0, "R1", "reset done", longint'(done), 0);
    chk(cmdReady == 1'b1, "R1", "reset cmdReady", longint'(cmdReady), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    // R2 unit words crossing a page: bank 0 to bank 1
    runVec(2'd0, 32'h1000_00F8, 0, 2, 6, 8'hFF, 8'hFF, "unit words");
    // R2 R6 unit bytes with stalls, bank 7 wraps to bank 0
    runVec(2'd0, 32'h0000_07FE, 0, 0, 5, 8'b1011_0110, 8'hFF, "unit bytes stalled");
    // R3 negative stride on halfwords
    runVec(2'd1, 32'h0000_0400, -3, 1, 4, 8'b1100_1101, 8'hFF, "negative stride");
    // R3 R6 stride of one page per element
    runVec(2'd1, 32'h0000_0000, 32, 3, 8, 8'b0111_1111, 8'hFF, "page stride");
    // R4 indexed gather with index gaps and stalls
    idxMem[0] = 5; idxMem[1] = -1; idxMem[2] = 64; idxMem[3] = 0; idxMem[4] = 3;
    runVec(2'd2, 32'h0000_2000, 0, 2, 5, 8'b1110_1011, 8'b1101_0111, "indexed");
    // R5 misaligned doublewords and halfwords
    runVec(2'd0, 32'h0000_0104, 0, 3, 3, 8'hFF, 8'hFF, "misaligned dwords");
    runVec(2'd1, 32'h0000_0101, 2, 1, 3, 8'hFF, 8'hFF, "misaligned halfs");
    // R7 zero length
    runVec(2'd0, 32'h0000_0040, 0, 2, 0, 8'hFF, 8'hFF, "zero length");
    // R10 reserved mode walks as unit
    runVec(2'd3, 32'h0000_0300, 7, 1, 4, 8'b1010_1111, 8'hFF, "reserved mode");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule